// File: doc/BRIEF.md
# Aliased Stack and Packed Register File

This block is a register file of eight 80-bit entries that two views share. The stack view names its registers relative to a top pointer, so ST(0) is the current top and ST(i) is the entry i places below it. It supports push, pop, write of ST(i) and combinational read of ST(i). The packed-integer view names the same physical entries by a fixed index from 0 to 7, with no regard to the top pointer. It reads and writes only the low 64 bits of an entry.

A write through the packed view fills the upper 16 bits of the target entry with ones. It also returns the stack to a known state: the top pointer goes to zero and every entry is marked full. A valid bit per entry lets the stack view detect a push onto an occupied slot (overflow) and a pop or read of an empty slot (underflow). A command that raises either flag leaves the state unchanged. Reads are combinational. Writes and pointer moves take effect on the rising clock edge.

Top module: `fpx_regstack`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets the top pointer to 0 and marks all entries empty, so a stack read of any ST(i) with `rd_en` high raises `unf`.
- R2: In stack mode (`mode`=0), `st_rdata` is the full 80-bit content of physical entry (top + `idx`) mod 8, and it is valid in the same cycle.
- R3: A push (`op`=01, stack mode) onto an empty slot first moves the top pointer down by one modulo 8, then stores `wdata` there. The previous ST(k) becomes ST(k+1).
- R4: A pop (`op`=10, stack mode) of a full ST(0) marks that entry empty and moves the top pointer up by one modulo 8. The popped value is `st_rdata` with `idx`=0 in the pop cycle.
- R5: A push whose target slot (top − 1) is already full raises `ovf` in that cycle and changes neither the contents, the valid bits nor the top pointer.
- R6: A pop of an empty ST(0), or any stack command issued with `rd_en` high while ST(`idx`) is empty, raises `unf` in that cycle and changes no state.
- R7: A stack write (`op`=11, stack mode) stores all 80 bits of `wdata` into ST(`idx`) and marks that entry full. The top pointer does not move.
- R8: `mm_rdata` is always bits 63:0 of physical entry `idx`, whatever the top pointer holds.
- R9: A packed write (`op`=11, `mode`=1) stores `wdata[63:0]` into bits 63:0 of entry `idx` and sets bits 79:64 to 16'hFFFF.
- R10: After a packed write the top pointer is 0 and all eight entries are full.
- R11: In packed mode, push and pop have no effect on state, and `ovf` and `unf` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 1 | 0 = stack view, 1 = packed view |
| op | input | 2 | 00 none, 01 push, 10 pop, 11 write |
| idx | input | 3 | ST(i) offset in stack view, absolute entry in packed view |
| rd_en | input | 1 | Stack read request, enables the empty-entry check on ST(idx) |
| wdata | input | 80 | Write data; packed writes use bits 63:0 |
| st_rdata | output | 80 | Content of ST(idx) |
| mm_rdata | output | 64 | Low 64 bits of entry idx |
| ovf | output | 1 | Stack overflow on the current command |
| unf | output | 1 | Stack underflow on the current command |

## Verification
The bench keeps its own eight-slot model and compares all four outputs after every command, over a full sweep of idx. It drives the top pointer through its wrap from 0 to 7 and back. A design with a wrong modulo or a wrong push order would return the wrong ST(i) once the pointer wraps. The bench pushes onto a full stack and pops past empty, so a design that moved the pointer on an error would show shifted data in the sweep that follows. Packed writes are read back through the stack view to catch upper bits that are not forced to ones and a top pointer that is not reset. Pushes and pops issued in packed mode are followed by sweeps, so a design that acted on them would be caught.

// File: rtl/fpx_regstack.sv
module fpx_regstack #(
  parameter int DEPTH = 8,
  parameter int EW    = 80,
  parameter int MW    = 64
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     mode,
  input  logic [1:0]               op,
  input  logic [$clog2(DEPTH)-1:0] idx,
  input  logic                     rd_en,
  input  logic [EW-1:0]            wdata,
  output logic [EW-1:0]            st_rdata,
  output logic [MW-1:0]            mm_rdata,
  output logic                     ovf,
  output logic                     unf
);
  localparam int IW = $clog2(DEPTH);
  localparam int UW = EW - MW;

  logic [EW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] valid;
  logic [IW-1:0]    top;
  logic [IW-1:0]    top_dn, phys;

  assign top_dn = top - 1'b1;
  assign phys   = top + idx;

  wire do_push = !mode && op == 2'b01;
  wire do_pop  = !mode && op == 2'b10;
  wire do_stwr = !mode && op == 2'b11;
  wire do_mmwr =  mode && op == 2'b11;

  assign st_rdata = mem[phys];
  assign mm_rdata = mem[idx][MW-1:0];
  assign ovf      = do_push && valid[top_dn];
  assign unf      = (do_pop && !valid[top]) || (!mode && rd_en && !valid[phys]);

  wire err = ovf || unf;

  always_ff @(posedge clk) begin
    if (rst) begin
      top   <= '0;
      valid <= '0;
      for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
    end else if (do_mmwr) begin
      mem[idx] <= {{UW{1'b1}}, wdata[MW-1:0]};
      top      <= '0;
      valid    <= '1;
    end else if (!err) begin
      if (do_push) begin
        mem[top_dn]   <= wdata;
        valid[top_dn] <= 1'b1;
        top           <= top_dn;
      end else if (do_pop) begin
        valid[top] <= 1'b0;
        top        <= top + 1'b1;
      end else if (do_stwr) begin
        mem[phys]   <= wdata;
        valid[phys] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/fpx_regstack_chk.sv
module fpx_regstack_chk #(
  parameter int DEPTH = 8,
  parameter int EW    = 80,
  parameter int MW    = 64
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     mode,
  input logic [1:0]               op,
  input logic [$clog2(DEPTH)-1:0] idx,
  input logic                     ovf,
  input logic                     unf,
  input logic [$clog2(DEPTH)-1:0] top,
  input logic [DEPTH-1:0]         valid,
  input logic [EW-1:0]            mem [DEPTH]
);
  localparam int IW = $clog2(DEPTH);

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (top == '0 && valid == '0)); // R1
  AST_PUSH_DEC: assert property (@(posedge clk) disable iff (rst)
    (!mode && op == 2'b01 && !ovf && !unf) |=> top == IW'($past(top) - 1'b1)); // R3
  AST_POP_INC: assert property (@(posedge clk) disable iff (rst)
    (!mode && op == 2'b10 && !unf) |=> top == IW'($past(top) + 1'b1)); // R4
  AST_OVF_FROZEN: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ($stable(top) && $stable(valid))); // R5
  AST_UNF_FROZEN: assert property (@(posedge clk) disable iff (rst)
    unf |=> ($stable(top) && $stable(valid))); // R6
  AST_MM_UPPER: assert property (@(posedge clk) disable iff (rst)
    (mode && op == 2'b11) |=> mem[$past(idx)][EW-1:MW] == '1); // R9
  AST_MM_RESTART: assert property (@(posedge clk) disable iff (rst)
    (mode && op == 2'b11) |=> (top == '0 && valid == '1)); // R10
  AST_MM_QUIET: assert property (@(posedge clk) disable iff (rst)
    mode |-> (!ovf && !unf)); // R11
endmodule

bind fpx_regstack fpx_regstack_chk #(.DEPTH(DEPTH), .EW(EW), .MW(MW)) u_chk (
  .clk(clk), .rst(rst), .mode(mode), .op(op), .idx(idx), .ovf(ovf), .unf(unf),
  .top(top), .valid(valid), .mem(mem)
);

// File: tb/fpx_regstack_bench.sv
module fpx_regstack_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [2:0]  idx = '0;
  logic        rd_en = 1'b0;
  logic [79:0] wdata = '0;
  logic [79:0] st_rdata;
  logic [63:0] mm_rdata;
  logic        ovf, unf;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [79:0] m_mem [8];
  logic [7:0]  m_val;
  logic [2:0]  m_top;

  always #2 clk = ~clk;

  fpx_regstack u_fpx_regstack (
    .clk(clk), .rst(rst), .mode(mode), .op(op), .idx(idx), .rd_en(rd_en),
    .wdata(wdata), .st_rdata(st_rdata), .mm_rdata(mm_rdata), .ovf(ovf), .unf(unf)
  );

  task automatic chk(string req, string what, logic [79:0] act, logic [79:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(string req, logic md, logic [1:0] o, logic [2:0] ix, logic re, logic [79:0] wd);
    logic [2:0] ph, td;
    logic e_ovf, e_unf;
    @(negedge clk);
    mode = md; op = o; idx = ix; rd_en = re; wdata = wd;
    #1;
    ph = m_top + ix;
    td = m_top - 3'd1;
    e_ovf = !md && o == 2'b01 && m_val[td];
    e_unf = !md && ((o == 2'b10 && !m_val[m_top]) || (re && !m_val[ph]));
    chk(req, "st_rdata", st_rdata, m_mem[ph]);
    chk(req, "mm_rdata", {16'h0, mm_rdata}, {16'h0, m_mem[ix][63:0]});
    chk(req, "ovf", {79'h0, ovf}, {79'h0, e_ovf});
    chk(req, "unf", {79'h0, unf}, {79'h0, e_unf});
    @(posedge clk);
    if (md && o == 2'b11) begin
      m_mem[ix] = {16'hFFFF, wd[63:0]}; m_top = 0; m_val = '1;
    end else if (!e_ovf && !e_unf && !md) begin
      if (o == 2'b01) begin m_mem[td] = wd; m_val[td] = 1'b1; m_top = td; end
      else if (o == 2'b10) begin m_val[m_top] = 1'b0; m_top = m_top + 3'd1; end
      else if (o == 2'b11) begin m_mem[ph] = wd; m_val[ph] = 1'b1; end
    end
  endtask

  task automatic sweep(string req);
    for (int i = 0; i < 8; i++) step(req, 1'b0, 2'b00, 3'(i), 1'b1, '0);
    for (int i = 0; i < 8; i++) step(req, 1'b1, 2'b00, 3'(i), 1'b0, '0);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; op = 2'b00; rd_en = 1'b0;
    @(posedge clk);
    for (int k = 0; k < 8; k++) m_mem[k] = '0;
    m_val = '0; m_top = 0;
    @(negedge clk); rst = 1'b0;
  endtask

  function automatic logic [79:0] pat(int k);
    return {16'h4000 + 16'(k), 32'hC0DE_0000 + 32'(k * 3), 32'h1357_9BDF ^ 32'(k << 8)};
  endfunction

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    sweep("R1");
    step("R6", 1'b0, 2'b10, 3'd0, 1'b0, '0);
    sweep("R6");
    for (int k = 0; k < 8; k++) begin
      step("R3", 1'b0, 2'b01, 3'd0, 1'b0, pat(k));
      sweep("R2");
    end
    step("R5", 1'b0, 2'b01, 3'd0, 1'b0, pat(99));
    sweep("R5");
    step("R7", 1'b0, 2'b11, 3'd3, 1'b0, 80'hDEAD_BEEF_0123_4567_89AB);
    sweep("R7");
    for (int k = 0; k < 3; k++) begin
      step("R4", 1'b0, 2'b10, 3'd0, 1'b0, '0);
      sweep("R4");
    end
    step("R6", 1'b0, 2'b00, 3'd7, 1'b1, '0);
    step("R6", 1'b0, 2'b11, 3'd7, 1'b1, pat(50));
    sweep("R6");
    for (int k = 0; k < 2; k++) step("R3", 1'b0, 2'b01, 3'd0, 1'b0, pat(20 + k));
    sweep("R2");
    for (int k = 0; k < 8; k++) step("R4", 1'b0, 2'b10, 3'd0, 1'b0, '0);
    step("R6", 1'b0, 2'b10, 3'd0, 1'b0, '0);
    sweep("R6");
    step("R3", 1'b0, 2'b01, 3'd0, 1'b0, pat(40));
    step("R3", 1'b0, 2'b01, 3'd0, 1'b0, pat(41));
    for (int k = 0; k < 8; k++) begin
      step("R9", 1'b1, 2'b11, 3'(7 - k), 1'b0, {16'h1234, 64'h0F0F_0000_0000_0000 + 64'(k * 17)});
      sweep("R10");
    end
    sweep("R8");
    step("R11", 1'b1, 2'b01, 3'd2, 1'b0, pat(77));
    sweep("R11");
    step("R11", 1'b1, 2'b10, 3'd5, 1'b0, '0);
    sweep("R11");
    step("R5", 1'b0, 2'b01, 3'd0, 1'b0, pat(78));
    step("R4", 1'b0, 2'b10, 3'd0, 1'b0, '0);
    step("R3", 1'b0, 2'b01, 3'd0, 1'b0, pat(79));
    sweep("R2");
    step("R4", 1'b0, 2'b10, 3'd0, 1'b0, '0);
    step("R4", 1'b0, 2'b10, 3'd0, 1'b0, '0);
    step("R10", 1'b1, 2'b11, 3'd4, 1'b0, 80'h0000_AAAA_BBBB_CCCC_DDDD);
    sweep("R10");
    do_reset();
    sweep("R1");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule